// File: doc/BRIEF.md
# Two-Stage Self-Test Signature Sequencer

This block runs the control side of a circular-path built-in self test. While it is idle, the registers on the path work as ordinary system registers. A start request makes the block clear the path to a known zero state. It then places the path in test mode, where every clock both compresses the responses and produces a new pseudo-random pattern. After each of two counted test sessions, the block compares a 24-bit window taken from the path against a golden value.

If the first comparison fails, the test stops at once. If it succeeds, a second, longer session follows, and the final verdict comes from the second comparison. Checking in two stages makes it less likely that a fault is hidden by aliasing in the compressor. A done flag and a pass flag report the result and keep it until the next test starts.

The tap width, both golden signatures, the length of the first session and the cumulative length at the end of the second session are all parameters. This lets short sessions stand in for the full lengths of 2^16 and 2^17 cycles.

Top module: `sig_bist_sequencer`

## Requirements
- R1: An active-high asynchronous reset forces the idle state at any time, including in the middle of a session. It also clears done and pass.
- R2: In idle, the mode output is 2'b00 (system). The block stays idle while start is low, and moves to initialise on the first clock edge at which start is high.
- R3: Initialise lasts one cycle, drives mode 2'b01, and clears done and pass. It is always followed by the first test session.
- R4: The first session drives mode 2'b10 for exactly SESS1_CYCLES cycles, counted from the end of initialise. A single compare cycle follows.
- R5: In the first compare cycle, a tap value other than SIG_FIRST ends the test: the block returns to idle with done=1 and pass=0. A failing run holds mode 2'b10 for SESS1_CYCLES+1 cycles in total.
- R6: When the tap equals SIG_FIRST in the first compare cycle, the second session follows. It runs until the cumulative test count reaches SESS_TOTAL_CYCLES, and a second compare cycle follows it. Both compare cycles keep mode 2'b10, so a full run holds mode 2'b10 for SESS_TOTAL_CYCLES+2 cycles.
- R7: In the second compare cycle, the block sets done=1 and sets pass=1 only if the tap equals SIG_FIRST's partner SIG_SECOND, then returns to idle. Pass is never 1 while done is 0.
- R8: Start is ignored from initialise until the block is back in idle.
- R9: Done and pass hold their values in idle until the next start.
- R10: The tap is sampled only in the two compare cycles. Its value during the sessions has no effect on the result.
- R11: The mode output never carries 2'b11, which is the scan code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| start_i | input | 1 | Starts a self test when the block is idle |
| sig_tap_i | input | TAP_W | Signature window taken from the circular path |
| path_mode_o | output | 2 | Mode code for the path registers: 00 system, 01 initialise, 10 test, 11 scan (never driven) |
| done_o | output | 1 | Set when a test has finished |
| pass_o | output | 1 | Set together with done when both signatures matched |

## Verification
The bench goes after off-by-one session lengths by counting the test-mode cycles of every run. A counter that ends one cycle early or late would change these counts of SESS1_CYCLES+1 and SESS_TOTAL_CYCLES+2. It fails the first signature on purpose to check the early abort; a design that ignored the first compare would still run the full length. It fails the second signature to check that pass stays low; a design that latched pass from the first compare would report a false pass. It drives noise on the tap during the sessions, holds start high in mid-run, and resets inside each session. A design that sampled the tap at the wrong time, restarted on start, or failed to abort would show up in the result flags or in the mode sequence.

// File: rtl/bist_seq_pkg.sv
package bist_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SYSTEM = 2'b00,
    MODE_INIT   = 2'b01,
    MODE_TEST   = 2'b10,
    MODE_SCAN   = 2'b11
  } path_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_INIT = 3'd1,
    ST_RUN1 = 3'd2,
    ST_CHK1 = 3'd3,
    ST_RUN2 = 3'd4,
    ST_CHK2 = 3'd5
  } seq_state_e;

  // True in the final cycle of a session that ends when the count reaches limit.
  function automatic logic is_last_tick(input logic [31:0] count, input logic [31:0] limit);
    return count == (limit - 32'd1);
  endfunction

  // Mode code presented to the path registers for each controller state.
  function automatic path_mode_e mode_for_state(input seq_state_e st);
    case (st)
      ST_IDLE: return MODE_SYSTEM;
      ST_INIT: return MODE_INIT;
      default: return MODE_TEST;
    endcase
  endfunction

endpackage

// File: rtl/bist_seq_counter.sv
module bist_seq_counter #(
  parameter int unsigned CNT_W        = 18,
  parameter int unsigned SESS1_CYCLES = 65536,
  parameter int unsigned SESS_TOTAL   = 131072
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             clear_i,
  input  logic             step_i,
  input  logic             in_run1_i,
  input  logic             in_run2_i,
  output logic             run1_last_o,
  output logic             run2_last_o,
  output logic [CNT_W-1:0] count_o
);
  import bist_seq_pkg::*;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i)        cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + CNT_W'(1);
  end

  assign run1_last_o = in_run1_i && is_last_tick(32'(cnt_q), SESS1_CYCLES);
  assign run2_last_o = in_run2_i && is_last_tick(32'(cnt_q), SESS_TOTAL);
  assign count_o     = cnt_q;

endmodule

// File: rtl/bist_seq_sigcmp.sv
module bist_seq_sigcmp #(
  parameter int unsigned      TAP_W      = 24,
  parameter logic [TAP_W-1:0] SIG_FIRST  = 24'h0FFA25,
  parameter logic [TAP_W-1:0] SIG_SECOND = 24'hC1275F
) (
  input  logic [TAP_W-1:0] tap_i,
  input  logic             sel_second_i,
  output logic             match_o
);
  logic [TAP_W-1:0] golden;

  always_comb begin
    golden  = sel_second_i ? SIG_SECOND : SIG_FIRST;
    match_o = (tap_i == golden);
  end

endmodule

// File: rtl/bist_seq_fsm.sv
module bist_seq_fsm (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     start_i,
  input  logic                     run1_last_i,
  input  logic                     run2_last_i,
  input  logic                     match_i,
  output bist_seq_pkg::seq_state_e state_o,
  output logic                     done_o,
  output logic                     pass_o,
  output logic                     clear_o,
  output logic                     step_o,
  output logic                     sel_second_o
);
  import bist_seq_pkg::*;

  seq_state_e state_q, state_d;
  logic       done_q, pass_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i)     state_d = ST_INIT;
      ST_INIT:                  state_d = ST_RUN1;
      ST_RUN1: if (run1_last_i) state_d = ST_CHK1;
      ST_CHK1:                  state_d = match_i ? ST_RUN2 : ST_IDLE;
      ST_RUN2: if (run2_last_i) state_d = ST_CHK2;
      ST_CHK2:                  state_d = ST_IDLE;
      default:                  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_INIT) begin
        done_q <= 1'b0;
        pass_q <= 1'b0;
      end
      if (state_q == ST_CHK1 && !match_i) begin
        done_q <= 1'b1;
        pass_q <= 1'b0;
      end
      if (state_q == ST_CHK2) begin
        done_q <= 1'b1;
        pass_q <= match_i;
      end
    end
  end

  assign state_o      = state_q;
  assign done_o       = done_q;
  assign pass_o       = pass_q;
  assign clear_o      = (state_q == ST_INIT);
  assign step_o       = (state_q == ST_RUN1) || (state_q == ST_RUN2);
  assign sel_second_o = (state_q == ST_CHK2);

endmodule

// File: rtl/sig_bist_sequencer.sv
module sig_bist_sequencer #(
  parameter int unsigned      TAP_W             = 24,
  parameter int unsigned      SESS1_CYCLES      = 65536,
  parameter int unsigned      SESS_TOTAL_CYCLES = 131072,
  parameter logic [TAP_W-1:0] SIG_FIRST         = 24'h0FFA25,
  parameter logic [TAP_W-1:0] SIG_SECOND        = 24'hC1275F
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             start_i,
  input  logic [TAP_W-1:0] sig_tap_i,
  output logic [1:0]       path_mode_o,
  output logic             done_o,
  output logic             pass_o
);
  import bist_seq_pkg::*;

  localparam int unsigned CNT_W = $clog2(SESS_TOTAL_CYCLES + 1);

  // Named internal events, visible to the bound checker.
  seq_state_e       state_q;
  logic [CNT_W-1:0] cycle_cnt;
  logic             run1_last, run2_last, sig_match;
  logic             cnt_clear, cnt_step, cmp_second;

  bist_seq_counter #(
    .CNT_W       (CNT_W),
    .SESS1_CYCLES(SESS1_CYCLES),
    .SESS_TOTAL  (SESS_TOTAL_CYCLES)
  ) counter_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .clear_i    (cnt_clear),
    .step_i     (cnt_step),
    .in_run1_i  (state_q == ST_RUN1),
    .in_run2_i  (state_q == ST_RUN2),
    .run1_last_o(run1_last),
    .run2_last_o(run2_last),
    .count_o    (cycle_cnt)
  );

  bist_seq_sigcmp #(
    .TAP_W     (TAP_W),
    .SIG_FIRST (SIG_FIRST),
    .SIG_SECOND(SIG_SECOND)
  ) sigcmp_i (
    .tap_i       (sig_tap_i),
    .sel_second_i(cmp_second),
    .match_o     (sig_match)
  );

  bist_seq_fsm fsm_i (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .start_i     (start_i),
    .run1_last_i (run1_last),
    .run2_last_i (run2_last),
    .match_i     (sig_match),
    .state_o     (state_q),
    .done_o      (done_o),
    .pass_o      (pass_o),
    .clear_o     (cnt_clear),
    .step_o      (cnt_step),
    .sel_second_o(cmp_second)
  );

  assign path_mode_o = mode_for_state(state_q);

endmodule

// File: rtl/bist_seq_checker.sv
module bist_seq_checker #(
  parameter int unsigned CNT_W        = 18,
  parameter int unsigned SESS1_CYCLES = 65536
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             start_i,
  input logic [1:0]       mode_i,
  input logic             done_i,
  input logic             pass_i,
  input logic [2:0]       state_i,
  input logic [CNT_W-1:0] count_i,
  input logic             match_i
);
  import bist_seq_pkg::*;

  always @(posedge clk_i) begin
    if (rst_i) begin
      assert_reset_idle_R1: assert (state_i == ST_IDLE && !done_i && !pass_i)
        else $error("reset did not force idle");
    end
  end

  assert_idle_system_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    state_i == ST_IDLE |-> mode_i == MODE_SYSTEM);

  assert_idle_start_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_i == ST_IDLE && start_i) |=> state_i == ST_INIT);

  assert_init_clears_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    state_i == ST_INIT |=> (state_i == ST_RUN1 && !done_i && !pass_i && mode_i == MODE_TEST));

  assert_run1_bound_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    state_i == ST_RUN1 |-> 32'(count_i) < SESS1_CYCLES);

  assert_chk1_abort_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_i == ST_CHK1 && !match_i) |=> (state_i == ST_IDLE && done_i && !pass_i));

  assert_chk1_continue_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_i == ST_CHK1 && match_i) |=> state_i == ST_RUN2);

  assert_chk2_verdict_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    state_i == ST_CHK2 |=> (done_i && pass_i == $past(match_i) && state_i == ST_IDLE));

  assert_pass_needs_done_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    pass_i |-> done_i);

  assert_run_ignores_start_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    state_i == ST_RUN1 |=> (state_i == ST_RUN1 || state_i == ST_CHK1));

  assert_flags_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (state_i == ST_IDLE && !start_i) |=> ($stable(done_i) && $stable(pass_i)));

  assert_no_scan_code_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    mode_i != MODE_SCAN);

endmodule

bind sig_bist_sequencer bist_seq_checker #(
  .CNT_W       (CNT_W),
  .SESS1_CYCLES(SESS1_CYCLES)
) chk_i (
  .clk_i  (clk_i),
  .rst_i  (rst_i),
  .start_i(start_i),
  .mode_i (path_mode_o),
  .done_i (done_o),
  .pass_i (pass_o),
  .state_i(state_q),
  .count_i(cycle_cnt),
  .match_i(sig_match)
);

// File: tb/sig_bist_sequencer_tb_top.sv
module sig_bist_sequencer_tb_top;

  localparam int          CLK_PERIOD = 10;
  localparam int          TAP_W      = 24;
  localparam int          S1         = 8;
  localparam int          S2         = 20;
  localparam logic [23:0] SIG1       = 24'h0FFA25;
  localparam logic [23:0] SIG2       = 24'hC1275F;
  localparam int          WATCHDOG   = 5000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic [TAP_W-1:0] tap = '0;
  logic [1:0]       mode;
  logic             done, pass;

  sig_bist_sequencer #(
    .TAP_W(TAP_W), .SESS1_CYCLES(S1), .SESS_TOTAL_CYCLES(S2),
    .SIG_FIRST(SIG1), .SIG_SECOND(SIG2)
  ) dut_i (
    .clk_i(clk), .rst_i(rst), .start_i(start), .sig_tap_i(tap),
    .path_mode_o(mode), .done_o(done), .pass_o(pass)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;

  // Reference model: 0 idle, 1 init, 2 run1, 3 cmp1, 4 run2, 5 cmp2
  int          m_st   = 0;
  int          m_cnt  = 0;
  bit          m_done = 1'b0;
  bit          m_pass = 1'b0;
  logic [23:0] tap_first_val  = SIG1;
  logic [23:0] tap_second_val = SIG2;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_st = 0; m_cnt = 0; m_done = 0; m_pass = 0;
    end else begin
      case (m_st)
        0: if (start) m_st = 1;
        1: begin m_done = 0; m_pass = 0; m_cnt = 0; m_st = 2; end
        2: begin m_cnt++; if (m_cnt == S1) m_st = 3; end
        3: if (tap == SIG1) m_st = 4; else begin m_done = 1; m_pass = 0; m_st = 0; end
        4: begin m_cnt++; if (m_cnt == S2) m_st = 5; end
        5: begin m_done = 1; m_pass = (tap == SIG2); m_st = 0; end
        default: m_st = 0;
      endcase
    end
  end

  // Per-cycle comparison against the model, then tap drive for the next edge.
  always @(negedge clk) begin
    string tag;
    int    exp_mode;
    cyc++;
    if (cyc > WATCHDOG) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=<%0d cycles", cyc, WATCHDOG);
      finish_run();
    end
    case (m_st)
      0: tag = "R2 idle";
      1: tag = "R3 init";
      2: tag = "R4 session1";
      3: tag = "R5 compare1";
      4: tag = "R6 session2";
      default: tag = "R7 compare2";
    endcase
    exp_mode = (m_st == 0) ? 0 : ((m_st == 1) ? 1 : 2);
    check({tag, " mode"}, 32'(mode), 32'(exp_mode));
    check({tag, " R9 done"}, 32'(done), 32'(m_done));
    check({tag, " R9 pass"}, 32'(pass), 32'(m_pass));
    check("R11 no scan code", 32'(mode == 2'b11), 32'd0);
    if (m_st == 3)      tap = tap_first_val;
    else if (m_st == 5) tap = tap_second_val;
    else                tap = 24'(cyc * 32'h9E3779B1);  // R10 noise in sessions
  end

  task automatic kick();
    @(negedge clk); #1 start = 1'b1;
    @(negedge clk); #1 start = 1'b0;
  endtask

  task automatic run_to_idle(output int tc);
    tc = 0;
    do begin
      @(negedge clk);
      if (mode == 2'b10) tc++;
    end while (m_st != 0);
  endtask

  initial begin
    int tc;
    repeat (3) @(negedge clk);
    check("R1 reset mode", 32'(mode), 32'd0);
    check("R1 reset done", 32'(done), 32'd0);
    check("R1 reset pass", 32'(pass), 32'd0);
    #1 rst = 1'b0;

    repeat (4) @(negedge clk);
    check("R2 stays idle with start low", 32'(mode), 32'd0);

    // Full passing run with noise on the tap during sessions
    kick();
    run_to_idle(tc);
    check("R6 full run test-mode cycles", 32'(tc), 32'(S2 + 2));
    check("R7 pass run done", 32'(done), 32'd1);
    check("R10 noise in sessions ignored, pass", 32'(pass), 32'd1);

    repeat (5) @(negedge clk);
    check("R9 done held in idle", 32'(done), 32'd1);
    check("R9 pass held in idle", 32'(pass), 32'd1);

    // First signature wrong: early abort
    tap_first_val = SIG1 ^ 24'h000100;
    kick();
    @(negedge clk);
    check("R3 init cleared done", 32'(done), 32'd0);
    check("R3 init cleared pass", 32'(pass), 32'd0);
    run_to_idle(tc);
    tc++;  // the sampled cycle above was in session 1
    check("R5 abort test-mode cycles", 32'(tc), 32'(S1 + 1));
    check("R5 abort done", 32'(done), 32'd1);
    check("R5 abort pass", 32'(pass), 32'd0);
    tap_first_val = SIG1;

    // Second signature wrong
    tap_second_val = SIG2 ^ 24'h000001;
    kick();
    run_to_idle(tc);
    check("R7 stage2 fail cycles", 32'(tc), 32'(S2 + 2));
    check("R7 stage2 fail done", 32'(done), 32'd1);
    check("R7 stage2 fail pass", 32'(pass), 32'd0);
    tap_second_val = SIG2;

    // Start held high in mid-run
    kick();
    tc = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (mode == 2'b10) tc++;
      if (m_st == 0 && i > 2) break;
      #1 start = (i >= 1 && i < 16);
    end
    #1 start = 1'b0;
    check("R8 start ignored, run length", 32'(tc), 32'(S2 + 2));
    check("R8 start ignored, pass", 32'(pass), 32'd1);

    // Reset abort inside session 1
    kick();
    repeat (3) @(negedge clk);
    #1 rst = 1'b1;
    @(negedge clk);
    check("R1 abort session1 mode", 32'(mode), 32'd0);
    check("R1 abort session1 done", 32'(done), 32'd0);
    #1 rst = 1'b0;

    // Reset abort inside session 2
    kick();
    repeat (S1 + 4) @(negedge clk);
    check("R6 in session2 before abort", 32'(mode), 32'd2);
    #1 rst = 1'b1;
    @(negedge clk);
    #1 rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 abort session2 idle", 32'(mode), 32'd0);
    check("R1 abort session2 pass", 32'(pass), 32'd0);

    // Recovery after abort
    kick();
    run_to_idle(tc);
    check("R7 recovery pass", 32'(pass), 32'd1);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule